// File: doc/BRIEF.md
# Serial Programming Host Controller

This block is the master side of a three-wire programming link to a small target that holds a few 8-bit settings. Each request carries an address, a data byte and a store flag. The block builds one frame on chip select, serial clock and serial data. It captures the byte that the target returns during that same frame. When a store is requested, it raises the program line with a guaranteed setup time ahead of the commit edge.

After the frame the serial clock keeps running. This lets the target finish its non-volatile write. The block watches the target's ready line and then reports one of three outcomes: success, a commit that never began, or a busy interval that ran past a timeout. A request is accepted only while the block is idle. Completion is a single-cycle pulse that carries the returned byte and two outcome flags.

Top module: `sprog_host`

## Requirements
- R1: While chip select is high it carries 1+ADDR_W+DATA_W bits. Bit 0 is a constant 1, then the address LSB first, then the data LSB first. Each bit is valid on the rising serial-clock edge, serial data changes only while the serial clock is low, and chip select drops after the last data bit's clock cycle.
- R2: The returned byte is sampled on the rising edges of bit positions 1+ADDR_W through FRAME_W-1. The first sample is bit 0 of the result, which appears on done_rdata during the done pulse.
- R3: With the store flag set, prog rises after the start bit's rising edge and at least SETUP_CYC system clocks before the first rising edge after the last data bit. SETUP_CYC is the setup time in ns multiplied by CLK_HZ and rounded up. With the store flag clear, prog stays low.
- R4: While prog is high, the serial clock keeps toggling every HALF_CYC system clocks until done.
- R5: On a store, ready is sampled half a serial period after the commit edge. If ready is still high, the request ends with done_fail=1 and done_timeout=0.
- R6: If ready has not returned high within TIMEOUT_CYC system clocks after the post-frame guard, the request ends with done_timeout=1 and done_fail=0. A normal store or a plain write ends with both flags 0.
- R7: At least two rising serial-clock edges follow the last data bit before chip select rises again.
- R8: req_ready is high only while idle, with chip select and prog low. A request is taken when req_valid and req_ready are both high. done is a one-cycle pulse, and prog falls in the cycle that done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Target register address |
| req_data | input | DATA_W | Byte to write |
| req_store | input | 1 | Also commit to non-volatile storage |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Byte returned by the target |
| done_fail | output | 1 | Commit never started |
| done_timeout | output | 1 | Busy interval exceeded the limit |
| cs | output | 1 | Chip select |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to target |
| sdi | input | 1 | Serial data from target |
| prog | output | 1 | Program strobe |
| rdy | input | 1 | Target ready (low while busy) |

## Verification
The bound checker watches every cycle for several properties: idle exclusivity of req_ready, single-cycle done, prog falling only with done, mutually exclusive outcome flags, data held while the serial clock is high, chip select rising with the clock low, and a serial clock that never stalls while prog is high. The setup lead of prog, the frame content, the returned byte, the guard edges before a new frame and the three outcomes depend on the target's reaction. Only the bench's scenarios can show these, using a behavioural target model that sweeps every address, several data patterns and both store settings, followed by a failed-commit case and a stuck-busy case.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2,
      ST_WAIT  = 2'd3
   } sprog_state_e;

   // Nanoseconds to system clocks, rounded up
   function automatic int ns_to_cycles(input longint hz, input longint ns);
      longint prod;
      prod = ns * hz + 64'd999_999_999;
      return int'(prod / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 1) begin : g_bad_stages
      $error("sprog_sync: STAGES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= RST_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sprog_sclk_gen.sv
module sprog_sclk_gen #(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_ev,
   output logic fall_ev
);
   localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [HW-1:0] HLAST = HW'(HALF_CYC - 1);

   logic [HW-1:0] hcnt;
   logic          wrap;

   if (HALF_CYC < 2) begin : g_bad_half
      $error("sprog_sclk_gen: HALF_CYC must be at least 2");
   end

   assign wrap    = run && (hcnt == HLAST);
   assign rise_ev = wrap && !sclk;
   assign fall_ev = wrap &&  sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         sclk <= 1'b0;
      end else if (!run) begin
         hcnt <= '0;
         sclk <= 1'b0;
      end else if (wrap) begin
         hcnt <= '0;
         sclk <= ~sclk;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end
endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              adv,
   input  logic              cap,
   input  logic              sdi,
   output logic              tx_bit,
   output logic [DATA_W-1:0] rx_data
);
   localparam int FRAME_W = 1 + ADDR_W + DATA_W;

   logic [FRAME_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tx_q <= '0;
      else if (load) tx_q <= {data, addr, 1'b1};
      else if (adv)  tx_q <= {1'b0, tx_q[FRAME_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rx_data <= '0;
      else if (load) rx_data <= '0;
      else if (cap)  rx_data <= {sdi, rx_data[DATA_W-1:1]};
   end

   assign tx_bit = tx_q[0];
endmodule

// File: rtl/sprog_host.sv
module sprog_host
   import sprog_pkg::*;
#(
   parameter longint CLK_HZ        = 100_000_000,
   parameter int     HALF_CYC      = 8,
   parameter int     ADDR_W        = 2,
   parameter int     DATA_W        = 8,
   parameter int     PROG_SETUP_NS = 150,
   parameter int     TIMEOUT_CYC   = 1_000_000,
   parameter int     RDY_SYNC      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_store,
   output logic              done,
   output logic [DATA_W-1:0] done_rdata,
   output logic              done_fail,
   output logic              done_timeout,
   output logic              cs,
   output logic              sclk,
   output logic              sdo,
   input  logic              sdi,
   output logic              prog,
   input  logic              rdy
);
   localparam int FRAME_W   = 1 + ADDR_W + DATA_W;
   localparam int DATA_LO   = 1 + ADDR_W;
   localparam int SETUP_CYC = ns_to_cycles(CLK_HZ, longint'(PROG_SETUP_NS));
   localparam int COMMIT_AT = (2 * FRAME_W + 1) * HALF_CYC;
   localparam int PROG_AT   = COMMIT_AT - SETUP_CYC;
   localparam int BIT_W     = $clog2(FRAME_W);
   localparam int FCNT_W    = $clog2(COMMIT_AT + 1);
   localparam int TCNT_W    = $clog2(TIMEOUT_CYC + 1);

   // Elaboration checks on the configuration
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sprog_host: ADDR_W and DATA_W must be positive");
   end
   if (SETUP_CYC < 1 || PROG_AT <= HALF_CYC) begin : g_bad_setup
      $error("sprog_host: program setup does not fit between start bit and commit edge");
   end
   if (HALF_CYC < RDY_SYNC + 2) begin : g_bad_sync
      $error("sprog_host: HALF_CYC too short for the ready synchroniser");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("sprog_host: TIMEOUT_CYC must be at least 2");
   end

   sprog_state_e      state;
   logic [BIT_W-1:0]  bidx;
   logic [FCNT_W-1:0] fcnt;
   logic [TCNT_W-1:0] tcnt;
   logic              store_q;
   logic              fail_seen;
   logic              prog_q;
   logic              done_q;
   logic              fail_q;
   logic              to_q;
   logic [DATA_W-1:0] rdata_q;

   logic              rdy_s;
   logic              run;
   logic              rise_ev;
   logic              fall_ev;
   logic              load;
   logic              adv;
   logic              cap;
   logic              tx_bit;
   logic [DATA_W-1:0] rx_data;
   logic              last_bit;
   logic              fin_tail;
   logic              fin_wait_ok;
   logic              fin_wait_to;
   logic              finish;

   sprog_sync #(.STAGES(RDY_SYNC), .RST_VAL(1'b1)) u_rdy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rdy),
      .q     (rdy_s)
   );

   sprog_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .sclk    (sclk),
      .rise_ev (rise_ev),
      .fall_ev (fall_ev)
   );

   sprog_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .addr    (req_addr),
      .data    (req_data),
      .adv     (adv),
      .cap     (cap),
      .sdi     (sdi),
      .tx_bit  (tx_bit),
      .rx_data (rx_data)
   );

   assign run       = (state != ST_IDLE);
   assign req_ready = (state == ST_IDLE);
   assign load      = req_ready && req_valid;
   assign cs        = (state == ST_SHIFT);
   assign sdo       = cs && tx_bit;
   assign last_bit  = (bidx == BIT_W'(FRAME_W - 1));
   assign adv       = cs && fall_ev;
   assign cap       = cs && rise_ev && (bidx >= BIT_W'(DATA_LO));

   assign fin_tail    = (state == ST_TAIL) && fall_ev && (bidx == BIT_W'(1))
                        && (!store_q || fail_seen);
   assign fin_wait_ok = (state == ST_WAIT) && fall_ev && rdy_s;
   assign fin_wait_to = (state == ST_WAIT) && !fin_wait_ok
                        && (tcnt == TCNT_W'(TIMEOUT_CYC - 1));
   assign finish      = fin_tail || fin_wait_ok || fin_wait_to;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bidx      <= '0;
         fcnt      <= '0;
         tcnt      <= '0;
         store_q   <= 1'b0;
         fail_seen <= 1'b0;
         prog_q    <= 1'b0;
         done_q    <= 1'b0;
         fail_q    <= 1'b0;
         to_q      <= 1'b0;
         rdata_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state     <= ST_SHIFT;
                  bidx      <= '0;
                  fcnt      <= '0;
                  store_q   <= req_store;
                  fail_seen <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (fall_ev) begin
                  if (last_bit) begin
                     state <= ST_TAIL;
                     bidx  <= '0;
                  end else begin
                     bidx <= bidx + 1'b1;
                  end
               end
            end
            ST_TAIL: begin
               if (fall_ev) begin
                  if (bidx == '0) begin
                     fail_seen <= store_q && rdy_s;
                     bidx      <= BIT_W'(1);
                  end else if (store_q && !fail_seen) begin
                     state <= ST_WAIT;
                     tcnt  <= '0;
                  end
               end
            end
            ST_WAIT: begin
               tcnt <= tcnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase

         if (run && fcnt != FCNT_W'(COMMIT_AT))
            fcnt <= fcnt + 1'b1;

         if (run && store_q && fcnt >= FCNT_W'(PROG_AT - 1))
            prog_q <= 1'b1;

         if (finish) begin
            state   <= ST_IDLE;
            done_q  <= 1'b1;
            fail_q  <= fin_tail && fail_seen;
            to_q    <= fin_wait_to;
            rdata_q <= rx_data;
            prog_q  <= 1'b0;
         end
      end
   end

   assign prog         = prog_q;
   assign done         = done_q;
   assign done_fail    = fail_q;
   assign done_timeout = to_q;
   assign done_rdata   = rdata_q;
endmodule

// File: rtl/sprog_host_chk.sv
module sprog_host_chk #(
   parameter int HALF_CYC = 8
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic cs,
   input logic sclk,
   input logic sdo,
   input logic prog,
   input logic done,
   input logic done_fail,
   input logic done_timeout
);
   logic sclk_d;
   int   stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         stall  <= 0;
      end else begin
         sclk_d <= sclk;
         if (sclk != sclk_d)     stall <= 0;
         else if (stall < 1000)  stall <= stall + 1;
      end
   end

   a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!cs && !prog));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_prog_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog) |-> done);

   a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(done_fail && done_timeout));

   a_r1_sdo_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && sclk && $past(sclk)) |-> $stable(sdo));

   a_r1_cs_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs) |-> !sclk);

   a_r4_sclk_alive: assert property (@(posedge clk) disable iff (!rst_n)
      prog |-> (stall < HALF_CYC));
endmodule

bind sprog_host sprog_host_chk #(.HALF_CYC(HALF_CYC)) u_sprog_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .cs           (cs),
   .sclk         (sclk),
   .sdo          (sdo),
   .prog         (prog),
   .done         (done),
   .done_fail    (done_fail),
   .done_timeout (done_timeout)
);

// File: tb/sprog_host_bench.sv
module sprog_host_bench;
   localparam int     PER   = 10;
   localparam longint CLKHZ = 100_000_000;
   localparam int     HALF  = 4;
   localparam int     NS    = 150;
   localparam int     TMO   = 600;
   localparam int     SYNC  = 2;
   localparam int     BUSY  = 12;
   localparam int     SETUP = (NS * int'(CLKHZ / 1_000_000) + 999) / 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [1:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic       req_store = 1'b0;
   logic       done;
   logic [7:0] done_rdata;
   logic       done_fail;
   logic       done_timeout;
   logic       cs, sclk, sdo, prog;
   logic       sdi_m = 1'b0;
   logic       rdy_m = 1'b1;

   always #(PER/2) clk = ~clk;

   sprog_host #(
      .CLK_HZ(CLKHZ), .HALF_CYC(HALF), .ADDR_W(2), .DATA_W(8),
      .PROG_SETUP_NS(NS), .TIMEOUT_CYC(TMO), .RDY_SYNC(SYNC)
   ) u_sprog_host (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_store(req_store),
      .done(done), .done_rdata(done_rdata), .done_fail(done_fail),
      .done_timeout(done_timeout), .cs(cs), .sclk(sclk), .sdo(sdo),
      .sdi(sdi_m), .prog(prog), .rdy(rdy_m)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Behavioural target
   int         rcnt = 0;
   logic [10:0] rxv = '0;
   logic [7:0] treg [4] = '{default: 8'h00};
   logic [7:0] cur = '0;
   logic       armed = 1'b0;
   int         busy_left = 0;
   int         busy_seen = 0;
   int         mode = 0;
   logic       start_prog = 1'b0;
   logic       commit_prog = 1'b0;
   longint     prog_rise_t = 0;
   longint     commit_t = 0;
   int         rises_after = 0;
   int         nframes = 0;
   logic       prog_seen = 1'b0;

   always @(posedge cs) begin
      if (nframes > 0) chk(rises_after >= 2, "R7 guard edges", rises_after, 2);
      nframes++;
      rcnt = 0;
   end

   always @(posedge sclk) begin
      if (cs) begin
         if (rcnt == 0) start_prog = prog;
         if (rcnt < 11) rxv[rcnt] = sdo;
         rcnt++;
         if (rcnt == 3) cur = treg[{rxv[2], rxv[1]}];
         if (rcnt == 11) begin
            treg[{rxv[2], rxv[1]}] = rxv[10:3];
            armed = 1'b1;
            rises_after = 0;
         end
      end else begin
         rises_after++;
         if (armed) begin
            armed = 1'b0;
            commit_prog = prog;
            commit_t = $time;
            if (prog) begin
               if (mode == 0) begin rdy_m = 1'b0; busy_left = BUSY; end
               else if (mode == 2) rdy_m = 1'b0;
            end
         end else if (busy_left > 0) begin
            busy_seen++;
            busy_left--;
            if (busy_left == 0) rdy_m = 1'b1;
         end
      end
   end

   always @(negedge sclk) begin
      if (cs && rcnt >= 3 && rcnt <= 10) sdi_m = cur[rcnt-3];
   end

   always @(posedge prog) prog_rise_t = $time;
   always @(posedge clk) if (prog) prog_seen = 1'b1;

   logic [7:0] exp_reg [4] = '{default: 8'h00};

   task automatic run_req(input int a, input logic [7:0] d, input bit st,
                          input int md, input bit ef, input bit et);
      logic [7:0] exp_rd;
      longint     t0;
      exp_rd    = exp_reg[a];
      mode      = md;
      busy_seen = 0;
      prog_seen = 1'b0;
      commit_prog = 1'b0;
      @(negedge clk);
      req_addr = 2'(a); req_data = d; req_store = st; req_valid = 1'b1;
      chk(req_ready, "R8 ready while idle", int'(req_ready), 1);
      t0 = $time;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R8 not ready when active", int'(req_ready), 0);
      while (!done) @(negedge clk);
      chk(done_rdata == exp_rd, "R2 readback", int'(done_rdata), int'(exp_rd));
      chk(rxv[0] == 1'b1, "R1 start bit", int'(rxv[0]), 1);
      chk({rxv[2], rxv[1]} == 2'(a), "R1 address", int'({rxv[2], rxv[1]}), a);
      chk(rxv[10:3] == d, "R1 data", int'(rxv[10:3]), int'(d));
      chk(done_fail == ef, "R5 fail flag", int'(done_fail), int'(ef));
      chk(done_timeout == et, "R6 timeout flag", int'(done_timeout), int'(et));
      if (st) begin
         chk(!start_prog, "R3 prog after start bit", int'(start_prog), 0);
         chk(commit_prog, "R3 prog at commit", int'(commit_prog), 1);
         chk((commit_t - prog_rise_t) / PER >= SETUP, "R3 setup lead",
             int'((commit_t - prog_rise_t) / PER), SETUP);
         if (md == 0)
            chk(busy_seen == BUSY - 1 || busy_seen == BUSY, "R4 clock through busy",
                busy_seen, BUSY);
         if (et)
            chk(($time - t0) / PER >= TMO, "R6 waited full limit",
                int'(($time - t0) / PER), TMO);
      end else begin
         chk(!prog_seen, "R3 prog low without store", int'(prog_seen), 0);
      end
      @(negedge clk);
      chk(!done, "R8 done one cycle", int'(done), 0);
      chk(!prog, "R8 prog low after done", int'(prog), 0);
      exp_reg[a] = d;
      rdy_m = 1'b1;
      busy_left = 0;
      mode = 0;
   endtask

   function automatic logic [7:0] pat(input int p, input int a);
      case (p)
         0: return 8'h00;
         1: return 8'hFF;
         2: return 8'hA5;
         3: return 8'h5A;
         4: return 8'(1 << (a + 3));
         default: return 8'(a * 53 + 17);
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && !cs && !sclk && !prog && !done, "R8 reset state",
          int'({req_ready, cs, sclk, prog, done}), 16);
      rst_n = 1'b1;
      @(negedge clk);
      for (int st = 0; st < 2; st++)
         for (int a = 0; a < 4; a++)
            for (int p = 0; p < 6; p++)
               run_req(a, pat(p, a), st[0], 0, 1'b0, 1'b0);
      run_req(1, 8'h3C, 1'b1, 1, 1'b1, 1'b0);
      run_req(2, 8'hC3, 1'b1, 1, 1'b1, 1'b0);
      run_req(3, 8'h96, 1'b1, 2, 1'b0, 1'b1);
      run_req(3, 8'h69, 1'b1, 0, 1'b0, 1'b0);
      run_req(0, 8'h42, 1'b0, 0, 1'b0, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(PER * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule